// File: doc/BRIEF.md
# Configuration Space Access Validator

This block sits between a host-side request port and a small set of device configuration spaces. Each request carries a packed configuration address, an access size in bytes, write data and, in the long form, a 64-bit bus identifier supplied as two 32-bit words. The block pulls the device/function number and a 12-bit register offset out of the packed address. It checks the request and then performs the access on the storage of the selected device. It answers every request with a status word and, for a successful read, a data word.

Each device slot has a device/function number and a space size, both set by parameters. Conventional slots hold 256 bytes and extended slots hold 4096 bytes. Any failure gives the same all-ones status and leaves the storage untouched. Reads and writes of 1, 2 or 4 bytes work on byte lanes inside the addressed 32-bit word.

Top module: `cfg_access_checker`

## Requirements
- R1: The device/function number is `cfgAddr[15:8]`. A request whose number matches no slot in `DEVFN_LIST` is rejected.
- R2: The register offset is 12 bits wide. Bits [11:8] come from `cfgAddr[27:24]` and bits [7:0] come from `cfgAddr[7:0]`. All other address bits are ignored.
- R3: `accSize` must be exactly 1, 2 or 4. Any other value is rejected.
- R4: The offset must be a multiple of the access size. A misaligned request is rejected.
- R5: The offset must be below the space size of the selected slot: 256 when its `EXT_MASK` bit is 0, and 4096 when that bit is 1. A request at or beyond the size is rejected.
- R6: The bus identifier is `{busHi, busLo}` when `reqLong` is 1 and 0 when `reqLong` is 0. It must equal `HOST_BUS_ID`, or the request is rejected.
- R7: `rspStatus` is 32'h0000_0000 on success and 32'hFFFF_FFFF on any rejection. No other value is ever returned.
- R8: A successful read sets `rspHasData`. `rspData` then carries the addressed bytes zero-extended and right-aligned: byte at the offset in [7:0], the next byte in [15:8], and so on. The word holds bytes in little-endian order.
- R9: A successful write of N bytes changes only the N addressed bytes of the target word. It takes the data from `wrData[8N-1:0]`. Its response has `rspHasData` = 0 and `rspData` = 0.
- R10: `rspDone` is high for exactly the one cycle after each cycle in which `reqValid` is high. It stays low otherwise, and it is low after reset.
- R11: A rejected request changes no storage. Its response has `rspHasData` = 0 and `rspData` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLong | input | 1 | 1 = bus identifier taken from busHi/busLo |
| cfgAddr | input | 32 | Packed configuration address |
| accSize | input | 32 | Access size in bytes |
| busHi | input | 32 | Bus identifier, upper word |
| busLo | input | 32 | Bus identifier, lower word |
| wrData | input | 32 | Write data, right-aligned |
| rspDone | output | 1 | One-cycle response strobe |
| rspStatus | output | 32 | 0 on success, all ones on failure |
| rspData | output | 32 | Read data, zero-extended |
| rspHasData | output | 1 | rspData holds a valid read result |

## Verification
A request is captured at the clock edge where `reqValid` is high. The status, data and done strobe for that request appear after the same edge and hold for one cycle. A write takes effect at that same edge, so a read issued on the very next cycle already returns the new bytes. The bench drives each request on a falling edge and samples the response on the next falling edge. After a gap it checks that done has dropped again, and its reference model is updated only at that response point.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;
  localparam int DEV_SEL_W   = 4;
  localparam int WORD_IDX_W  = 10;
  localparam int BASE_BYTES  = 256;
  localparam int EXT_BYTES   = 4096;
  localparam logic [31:0] STATUS_OK  = 32'h0000_0000;
  localparam logic [31:0] STATUS_ERR = 32'hFFFF_FFFF;

  typedef struct packed {
    logic                  rdEn;
    logic                  wrEn;
    logic                  fault;
    logic [DEV_SEL_W-1:0]  devSel;
    logic [WORD_IDX_W-1:0] wordIdx;
    logic [1:0]            byteOff;
    logic [3:0]            laneMask;
  } cfgStrobes_t;
endpackage

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfg_access_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter logic [NUM_DEV*8-1:0] DEVFN_LIST = 24'h19_10_08,
  parameter logic [NUM_DEV-1:0] EXT_MASK = 3'b010,
  parameter logic [63:0] HOST_BUS_ID = 64'd0
) (
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqLong,
  input  logic [31:0] cfgAddr,
  input  logic [31:0] accSize,
  input  logic [31:0] busHi,
  input  logic [31:0] busLo,
  output cfgStrobes_t strb
);
  logic [7:0]  devfn;
  logic [11:0] offset;
  logic        sizeOk, hit, isExt, aligned, inBounds, busOk, reqOk;
  logic [DEV_SEL_W-1:0] sel;
  logic [63:0] busId;
  logic [3:0]  baseMask;

  assign devfn  = cfgAddr[15:8];
  assign offset = {cfgAddr[27:24], cfgAddr[7:0]};
  assign busId  = reqLong ? {busHi, busLo} : 64'd0;
  assign busOk  = (busId == HOST_BUS_ID);

  always_comb begin
    sizeOk   = 1'b1;
    aligned  = 1'b1;
    baseMask = 4'b0000;
    case (accSize)
      32'd1: baseMask = 4'b0001;
      32'd2: begin baseMask = 4'b0011; aligned = (offset[0] == 1'b0); end
      32'd4: begin baseMask = 4'b1111; aligned = (offset[1:0] == 2'b00); end
      default: sizeOk = 1'b0;
    endcase
  end

  always_comb begin
    hit   = 1'b0;
    sel   = '0;
    isExt = 1'b0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (DEVFN_LIST[i*8 +: 8] == devfn) begin
        hit   = 1'b1;
        sel   = DEV_SEL_W'(i);
        isExt = EXT_MASK[i];
      end
    end
  end

  assign inBounds = isExt || (offset[11:8] == 4'h0);
  assign reqOk    = sizeOk && hit && aligned && inBounds && busOk;

  always_comb begin
    strb.rdEn     = reqValid && reqOk && !reqWrite;
    strb.wrEn     = reqValid && reqOk && reqWrite;
    strb.fault    = !reqOk;
    strb.devSel   = sel;
    strb.wordIdx  = offset[11:2];
    strb.byteOff  = offset[1:0];
    strb.laneMask = baseMask << offset[1:0];
  end
endmodule

// File: rtl/cfg_access_datapath.sv
module cfg_access_datapath
  import cfg_access_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter logic [NUM_DEV-1:0] EXT_MASK = 3'b010
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] wrData,
  input  cfgStrobes_t strb,
  output logic        rspDone,
  output logic [31:0] rspStatus,
  output logic [31:0] rspData,
  output logic        rspHasData
);
  localparam int EXT_WORDS  = EXT_BYTES / 4;
  localparam int BASE_WORDS = BASE_BYTES / 4;

  logic [31:0] rdWords [NUM_DEV];
  logic [31:0] selWord, laneBits, readVal, wrShift;

  assign wrShift = wrData << {strb.byteOff, 3'b000};

  for (genvar g = 0; g < NUM_DEV; g++) begin : gDev
    localparam int DEPTH = EXT_MASK[g] ? EXT_WORDS : BASE_WORDS;
    localparam int AW    = $clog2(DEPTH);
    logic [31:0] mem [DEPTH];
    logic [AW-1:0] idx;
    logic hereWr;

    assign idx        = strb.wordIdx[AW-1:0];
    assign hereWr     = strb.wrEn && (strb.devSel == DEV_SEL_W'(g));
    assign rdWords[g] = mem[idx];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      end else if (hereWr) begin
        for (int b = 0; b < 4; b++) begin
          if (strb.laneMask[b]) mem[idx][8*b +: 8] <= wrShift[8*b +: 8];
        end
      end
    end
  end

  always_comb begin
    selWord = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (strb.devSel == DEV_SEL_W'(i)) selWord = rdWords[i];
    end
  end

  always_comb begin
    for (int b = 0; b < 4; b++) laneBits[8*b +: 8] = {8{strb.laneMask[b]}};
  end

  assign readVal = (selWord & laneBits) >> {strb.byteOff, 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspDone    <= 1'b0;
      rspStatus  <= STATUS_OK;
      rspData    <= '0;
      rspHasData <= 1'b0;
    end else begin
      rspDone    <= reqValid;
      rspHasData <= strb.rdEn;
      if (reqValid) begin
        rspStatus <= strb.fault ? STATUS_ERR : STATUS_OK;
        rspData   <= strb.rdEn ? readVal : 32'd0;
      end
    end
  end
endmodule

// File: rtl/cfg_access_checker.sv
module cfg_access_checker
  import cfg_access_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter logic [NUM_DEV*8-1:0] DEVFN_LIST = 24'h19_10_08,
  parameter logic [NUM_DEV-1:0] EXT_MASK = 3'b010,
  parameter logic [63:0] HOST_BUS_ID = 64'd0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqLong,
  input  logic [31:0] cfgAddr,
  input  logic [31:0] accSize,
  input  logic [31:0] busHi,
  input  logic [31:0] busLo,
  input  logic [31:0] wrData,
  output logic        rspDone,
  output logic [31:0] rspStatus,
  output logic [31:0] rspData,
  output logic        rspHasData
);
  cfgStrobes_t strb;

  cfg_access_ctrl #(
    .NUM_DEV(NUM_DEV), .DEVFN_LIST(DEVFN_LIST),
    .EXT_MASK(EXT_MASK), .HOST_BUS_ID(HOST_BUS_ID)
  ) uCtrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqLong(reqLong),
    .cfgAddr(cfgAddr), .accSize(accSize), .busHi(busHi), .busLo(busLo),
    .strb(strb)
  );

  cfg_access_datapath #(
    .NUM_DEV(NUM_DEV), .EXT_MASK(EXT_MASK)
  ) uData (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wrData(wrData),
    .strb(strb), .rspDone(rspDone), .rspStatus(rspStatus),
    .rspData(rspData), .rspHasData(rspHasData)
  );
endmodule

// File: rtl/cfg_access_checker_sva.sv
module cfg_access_checker_sva (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [31:0] cfgAddr,
  input logic [31:0] accSize,
  input logic        rspDone,
  input logic [31:0] rspStatus,
  input logic [31:0] rspData,
  input logic        rspHasData
);
  assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspDone);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspDone);
  assert_status_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (rspStatus == 32'h0 || rspStatus == 32'hFFFF_FFFF));
  assert_bad_size_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accSize != 32'd1 && accSize != 32'd2 && accSize != 32'd4)
      |=> (rspStatus == 32'hFFFF_FFFF && !rspHasData));
  assert_misaligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accSize == 32'd4 && cfgAddr[1:0] != 2'b00)
      |=> rspStatus == 32'hFFFF_FFFF);
  assert_write_nodata_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (!rspHasData && rspData == 32'd0));
  assert_byte_zero_ext_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accSize == 32'd1) |=> rspData[31:8] == 24'd0);
  assert_data_with_ok_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspHasData |-> rspStatus == 32'h0);
endmodule

bind cfg_access_checker cfg_access_checker_sva uSva (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .cfgAddr(cfgAddr), .accSize(accSize), .rspDone(rspDone),
  .rspStatus(rspStatus), .rspData(rspData), .rspHasData(rspHasData)
);

// File: tb/cfg_access_checker_test.sv
module cfg_access_checker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqLong = 1'b0;
  logic [31:0] cfgAddr = '0, accSize = '0, busHi = '0, busLo = '0, wrData = '0;
  logic        rspDone, rspHasData;
  logic [31:0] rspStatus, rspData;

  int checks = 0;
  int fails = 0;
  bit [31:0] modelMem [int];

  always #4 clk = ~clk;

  cfg_access_checker #(
    .NUM_DEV(3), .DEVFN_LIST(24'h19_10_08), .EXT_MASK(3'b010), .HOST_BUS_ID(64'd0)
  ) uut (.*);

  function automatic int devIndex(input logic [7:0] df);
    case (df)
      8'h08: return 0;
      8'h10: return 1;
      8'h19: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] mkAddr(input logic [7:0] df, input logic [11:0] off,
                                         input logic [3:0] junkHi, input logic [7:0] junkMid);
    return {junkHi, off[11:8], junkMid, df, off[7:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one request, compare the response with the bench model.
  task automatic doReq(input bit wr, input bit lng, input logic [31:0] addr,
                       input logic [31:0] sz, input logic [31:0] hi, input logic [31:0] lo,
                       input logic [31:0] wd, input string tag);
    logic [11:0] off;
    int di, key;
    bit ok;
    logic [31:0] word, expData, expStat;
    off = {addr[27:24], addr[7:0]};
    di  = devIndex(addr[15:8]);
    ok  = (sz == 1 || sz == 2 || sz == 4) && di >= 0 && (off % sz[11:0]) == 0
          && (di == 1 || off < 12'd256) && (!lng || {hi, lo} == 64'd0);
    key = di * 1024 + int'(off[11:2]);
    word = (ok && modelMem.exists(key)) ? modelMem[key] : 32'd0;
    expStat = ok ? 32'h0 : 32'hFFFF_FFFF;
    expData = 32'd0;
    if (ok && !wr) begin
      expData = word >> (8 * off[1:0]);
      if (sz == 1) expData &= 32'hFF;
      if (sz == 2) expData &= 32'hFFFF;
    end
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqLong = lng; cfgAddr = addr;
    accSize = sz; busHi = hi; busLo = lo; wrData = wd;
    @(negedge clk);
    reqValid = 1'b0;
    check(rspDone == 1'b1, {tag, " R10 done"}, {31'd0, rspDone}, 32'd1);
    check(rspStatus == expStat, {tag, " R7 status"}, rspStatus, expStat);
    check(rspData == expData, {tag, " R8 data"}, rspData, expData);
    check(rspHasData == (ok && !wr), {tag, " R11 hasData"}, {31'd0, rspHasData},
          {31'd0, ok && !wr});
    if (ok && wr) begin
      for (int b = 0; b < 4; b++) begin
        if (b >= int'(off[1:0]) && b < int'(off[1:0]) + int'(sz))
          word[8*b +: 8] = wd[8*(b - int'(off[1:0])) +: 8];
      end
      modelMem[key] = word;
    end
  endtask

  task automatic expectLast(input logic [31:0] exp, input string tag);
    check(rspData == exp, tag, rspData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R10 actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] dfs [4];
    int szs [6];
    dfs = '{8'h08, 8'h10, 8'h19, 8'h20};
    szs = '{1, 2, 4, 4, 3, 0};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(rspDone == 1'b0 && rspStatus == 32'd0 && rspData == 32'd0,
          "R10 reset state", {31'd0, rspDone}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R8 R9: lane-level reads and writes
    doReq(1, 0, mkAddr(8'h08, 12'h010, 4'h0, 8'h00), 4, 0, 0, 32'hA5A5_1234, "R9 w4");
    doReq(1, 0, mkAddr(8'h08, 12'h011, 4'h0, 8'h00), 1, 0, 0, 32'h0000_00FF, "R9 w1");
    doReq(0, 0, mkAddr(8'h08, 12'h010, 4'h0, 8'h00), 4, 0, 0, 0, "R9 rd4");
    expectLast(32'hA5A5_FF34, "R9 byte merge");
    doReq(0, 0, mkAddr(8'h08, 12'h012, 4'h0, 8'h00), 2, 0, 0, 0, "R8 rd2");
    expectLast(32'h0000_A5A5, "R8 half right-aligned");
    doReq(0, 0, mkAddr(8'h08, 12'h013, 4'h0, 8'h00), 1, 0, 0, 0, "R8 rd1");
    expectLast(32'h0000_00A5, "R8 byte right-aligned");
    // R3 sizes
    doReq(0, 0, mkAddr(8'h08, 12'h010, 4'h0, 8'h00), 3, 0, 0, 0, "R3 size3");
    doReq(0, 0, mkAddr(8'h08, 12'h010, 4'h0, 8'h00), 0, 0, 0, 0, "R3 size0");
    doReq(1, 0, mkAddr(8'h08, 12'h010, 4'h0, 8'h00), 8, 0, 0, 32'h1, "R3 size8");
    // R4 alignment, R11 no storage change on reject
    doReq(0, 0, mkAddr(8'h08, 12'h011, 4'h0, 8'h00), 2, 0, 0, 0, "R4 mis2");
    doReq(1, 0, mkAddr(8'h08, 12'h012, 4'h0, 8'h00), 4, 0, 0, 32'h0, "R4 mis4");
    doReq(0, 0, mkAddr(8'h08, 12'h010, 4'h0, 8'h00), 4, 0, 0, 0, "R11 readback");
    expectLast(32'hA5A5_FF34, "R11 storage kept");
    // R5 bounds, R2 offset composition
    doReq(0, 0, mkAddr(8'h08, 12'h100, 4'h0, 8'h00), 4, 0, 0, 0, "R5 conv oob");
    doReq(0, 0, mkAddr(8'h19, 12'h0FC, 4'h0, 8'h00), 4, 0, 0, 0, "R5 conv last");
    doReq(1, 0, mkAddr(8'h10, 12'h3FC, 4'hF, 8'hAB), 4, 0, 0, 32'hDEAD_BEEF, "R2 ext w");
    doReq(0, 0, mkAddr(8'h10, 12'h0FC, 4'h0, 8'h00), 4, 0, 0, 0, "R2 alias");
    expectLast(32'h0, "R2 low offset distinct");
    doReq(0, 0, mkAddr(8'h10, 12'h3FC, 4'h5, 8'h11), 4, 0, 0, 0, "R2 ext r");
    expectLast(32'hDEAD_BEEF, "R2 high offset bits");
    doReq(0, 0, mkAddr(8'h10, 12'hFFC, 4'h0, 8'h00), 4, 0, 0, 0, "R5 ext top");
    // R1 device select
    doReq(0, 0, mkAddr(8'h20, 12'h010, 4'h0, 8'h00), 4, 0, 0, 0, "R1 nodev");
    doReq(1, 0, mkAddr(8'h19, 12'h020, 4'h0, 8'h00), 2, 0, 0, 32'h0000_BEEF, "R1 dev2");
    // R6 bus id
    doReq(0, 1, mkAddr(8'h19, 12'h020, 4'h0, 8'h00), 2, 0, 0, 0, "R6 long zero");
    expectLast(32'h0000_BEEF, "R6 long ok data");
    doReq(0, 1, mkAddr(8'h19, 12'h020, 4'h0, 8'h00), 2, 32'h1, 0, 0, "R6 hi bad");
    doReq(0, 1, mkAddr(8'h19, 12'h020, 4'h0, 8'h00), 2, 0, 32'h5, 0, "R6 lo bad");
    doReq(0, 0, mkAddr(8'h19, 12'h020, 4'h0, 8'h00), 2, 32'h7, 32'h9, 0, "R6 short");
    // R10 done drops when idle
    @(negedge clk);
    check(rspDone == 1'b0, "R10 idle done low", {31'd0, rspDone}, 32'd0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [11:0] off;
      logic [7:0] df;
      off = 12'($urandom_range(0, 4095));
      if ($urandom_range(0, 3) != 0) off[11:8] = 4'($urandom_range(0, 1));
      if ($urandom_range(0, 1) != 0) off[7:0] = {off[7:2] & 6'h07, off[1:0]};
      df = dfs[$urandom_range(0, 3)];
      doReq($urandom_range(0, 1) == 1, $urandom_range(0, 4) == 0,
            mkAddr(df, off, 4'($urandom), 8'($urandom)),
            32'(szs[$urandom_range(0, 5)]),
            ($urandom_range(0, 3) == 0) ? 32'h1 : 32'h0, 32'h0, $urandom, "rand");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule